// File: doc/BRIEF.md
# Periodic Clock Timer with Restart Control

This block is a small free-running timer for a low-rate timebase. A 7-stage binary counter advances once for every pulse on a 256 Hz enable input, which an external divider supplies. Its four slowest stages, which toggle at 16, 8, 4 and 2 Hz, are the only part software can see. Software reads them through a simple register bus in one access, so a read never mixes stages from before and after a tick.

Software restarts the count by writing a 1 to a restart bit. That bit holds no state and always reads back as 0. Each time the counter wraps from all ones to zero, the timer latches an interrupt factor flag. Reading the flag clears it. The flag is gated with a mask input to form the interrupt request.

The bus has separate read and write strobes and no stall. Every access completes in one cycle, so the block applies no back-pressure. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `clock_timer`

## Requirements
- R1: Each cycle in which `tick_i` is 1 and no restart is written, the 7-bit counter increments by one, wrapping from 127 to 0. With no tick and no restart, the counter holds its value.
- R2: A read at address 0 returns counter bits 6..3 on `bus_rdata_o[3:0]` in the cycle after the read strobe. Bit 6 goes to bit 3 (the 2 Hz stage) and bit 3 goes to bit 0 (the 16 Hz stage). All four bits come from the same clock edge.
- R3: A write to address 1 with `bus_wdata_i[0]` = 1 sets the counter to 0 at that edge. Counting resumes with the next tick.
- R4: A write to address 1 with `bus_wdata_i[0]` = 0 leaves the counter and the flag unchanged. A later readout at address 0 shows this.
- R5: A read at address 1 always returns 0.
- R6: A tick that takes the counter from 127 to 0 sets the factor flag. The flag is read at address 2, bit 0.
- R7: When a restart write and a tick arrive in the same cycle, the counter becomes 0. Such a cycle never sets the flag, even when the counter was at 127.
- R8: A read at address 2 returns the flag and then clears it. If a wrap occurs in the same cycle as that read, the flag stays set.
- R9: `irq_o` equals the flag AND `irq_mask_i`. A low mask leaves the flag itself unchanged.
- R10: While `rst_n` is low, the counter, the flag and `bus_rdata_o` are 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 256 Hz count enable |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 4 | Write data |
| bus_rdata_o | output | 4 | Read data, valid one cycle after the strobe |
| irq_mask_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 7-bit counter, a 4-bit visible field and a 2-bit address. At these sizes a full wrap takes only 128 ticks, so the bench drives several wraps in a short run. Those wraps cover the flag set, the clear-on-read race and a restart that coincides with the wrap tick. A 4-bit field also lets every readout value appear many times during the pseudo-random phase.

// File: rtl/clock_timer_pkg.sv
package clock_timer_pkg;
  parameter int unsigned CNT_W  = 7;
  parameter int unsigned VIS_W  = 4;
  parameter int unsigned ADDR_W = 2;
  parameter int unsigned DATA_W = 4;

  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(2);
  localparam int unsigned RESTART_BIT = 0;
endpackage

// File: rtl/clock_timer_counter.sv
module clock_timer_counter #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  // restart wins over tick; a restart cycle never reports a wrap
  assign wrap = tick & ~restart & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/clock_timer_flag.sv
module clock_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/clock_timer_regs.sv
module clock_timer_regs
  import clock_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output logic              restart,
  output logic              flag_clr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned LO = CNT_W - VIS_W;

  logic [DATA_W-1:0] rnext;
  logic [DATA_W-1:0] wdata_unused;

  assign wdata_unused = wdata;
  assign restart  = wr & (addr == A_CTRL) & wdata[RESTART_BIT];
  assign flag_clr = rd & (addr == A_FLAG);

  always_comb begin
    rnext = '0;
    unique case (addr)
      A_TIME:  rnext[VIS_W-1:0] = cnt[CNT_W-1:LO];
      A_FLAG:  rnext[0] = flag;
      default: rnext = '0;
    endcase
  end

  // whole field captured at one edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rnext;
  end
endmodule

// File: rtl/clock_timer.sv
module clock_timer
  import clock_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              irq_mask_i,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             restart;
  logic             flag_clr;
  logic             flag;

  clock_timer_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .restart(restart),
    .cnt(cnt), .wrap(wrap)
  );

  clock_timer_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(wrap), .clr(flag_clr), .flag(flag)
  );

  clock_timer_regs u_regs (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd_i), .wr(bus_wr_i),
    .addr(bus_addr_i), .wdata(bus_wdata_i), .cnt(cnt), .flag(flag),
    .restart(restart), .flag_clr(flag_clr), .rdata(bus_rdata_o)
  );

  assign irq_o = flag & irq_mask_i;
endmodule

// File: rtl/clock_timer_chk.sv
module clock_timer_chk
  import clock_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_mask_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt,
  input logic              flag
);
  logic rs;
  assign rs = bus_wr_i && (bus_addr_i == A_CTRL) && bus_wdata_i[RESTART_BIT];

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !rs |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !rs |=> $stable(cnt));
  // R3
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs |=> cnt == '0);
  // R5
  ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_i && bus_addr_i == A_CTRL |=> bus_rdata_o == '0);
  // R6
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !rs && (&cnt) |=> flag);
  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_mask_i && flag);
endmodule

bind clock_timer clock_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_rd_i(bus_rd_i),
  .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o), .irq_mask_i(irq_mask_i), .irq_o(irq_o),
  .cnt(cnt), .flag(flag)
);

// File: tb/clock_timer_bench.sv
module clock_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       bus_rd_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [3:0] bus_wdata_i = 4'd0;
  logic [3:0] bus_rdata_o;
  logic       irq_mask_i = 1'b0;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R10";

  int       m_cnt = 0;
  bit       m_flag = 1'b0;
  bit [3:0] m_rdata = 4'd0;

  always #4 clk = ~clk;

  clock_timer u_clock_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_rd_i(bus_rd_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_mask_i(irq_mask_i), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, evaluated on inputs held across the edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_flag = 1'b0; m_rdata = 4'd0;
    end else begin
      bit rs, wr_evt;
      rs = bus_wr_i && bus_addr_i == 2'd1 && bus_wdata_i[0];
      wr_evt = tick_i && !rs && m_cnt == 127;
      if (bus_rd_i) begin
        if (bus_addr_i == 2'd0) m_rdata = 4'(m_cnt / 8);
        else if (bus_addr_i == 2'd2) m_rdata = {3'b000, m_flag};
        else m_rdata = 4'd0;
      end
      if (wr_evt) m_flag = 1'b1;
      else if (bus_rd_i && bus_addr_i == 2'd2) m_flag = 1'b0;
      if (rs) m_cnt = 0;
      else if (tick_i) m_cnt = (m_cnt + 1) % 128;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(bus_rdata_o == m_rdata, tag, bus_rdata_o, m_rdata);
      chk(irq_o == (m_flag & irq_mask_i), {tag, " R9"}, irq_o, m_flag & irq_mask_i);
    end
  end

  task automatic drive(input bit t, input bit rd, input bit wr, input bit [1:0] a, input bit [3:0] wd);
    @(posedge clk); #1;
    tick_i = t; bus_rd_i = rd; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = wd;
  endtask

  task automatic read_exp(input bit [1:0] a, input int exp, input string req);
    drive(0, 1, 0, a, 0);
    drive(0, 0, 0, 0, 0);
    @(negedge clk);
    chk(bus_rdata_o == 4'(exp), req, bus_rdata_o, exp);
  endtask

  task automatic ticks(input int n, input bit rd);
    for (int i = 0; i < n; i++) drive(1, rd, 0, 2'd0, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bus_rdata_o == 0, "R10", bus_rdata_o, 0);
    chk(irq_o == 0, "R10", irq_o, 0);
    #1 rst_n = 1'b1;
    read_exp(2'd3, 0, "R10");

    tag = "R1 R2";
    ticks(40, 1'b1);
    read_exp(2'd0, 5, "R2");

    tag = "R4";
    drive(0, 0, 1, 2'd1, 4'b1110);
    read_exp(2'd0, 5, "R4");

    tag = "R3";
    drive(0, 0, 1, 2'd1, 4'b0001);
    read_exp(2'd0, 0, "R3");
    ticks(8, 1'b0);
    read_exp(2'd0, 1, "R3");

    tag = "R7";
    ticks(30, 1'b0);
    drive(1, 0, 1, 2'd1, 4'b0001);
    read_exp(2'd0, 0, "R7");

    tag = "R5";
    read_exp(2'd1, 0, "R5");

    tag = "R6";
    irq_mask_i = 1'b0;
    drive(0, 0, 1, 2'd1, 4'b0001);
    ticks(128, 1'b0);
    read_exp(2'd0, 0, "R6");
    chk(irq_o == 0, "R9", irq_o, 0);
    irq_mask_i = 1'b1;
    @(negedge clk);
    chk(irq_o == 1, "R9", irq_o, 1);

    tag = "R8";
    ticks(127, 1'b0);
    drive(1, 1, 0, 2'd2, 0);
    drive(0, 0, 0, 0, 0);
    @(negedge clk);
    chk(bus_rdata_o == 1, "R8", bus_rdata_o, 1);
    read_exp(2'd2, 1, "R8");
    read_exp(2'd2, 0, "R8");
    chk(irq_o == 0, "R8", irq_o, 0);

    tag = "R7";
    ticks(127, 1'b0);
    drive(1, 0, 1, 2'd1, 4'b0001);
    read_exp(2'd2, 0, "R7");

    tag = "R1 R2 R6 R8";
    for (int i = 0; i < 4000; i++) begin
      automatic int r = $urandom;
      drive(r[0] | r[1], r[2] & r[3], (r[11:4] == 0), 2'(r[13:12]), 4'(r[17:14]));
      if (r[25:20] == 0) irq_mask_i = ~irq_mask_i;
    end
    drive(0, 0, 0, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule